// File: doc/BRIEF.md
# Real-Time Clock Prescaler and Rate Tap Selector

This block sits between a 32.768 kHz time-base enable and the interrupt and timekeeping logic of a real-time clock. It divides the time base through a 15-stage binary chain, produces a once-per-second tick for the calendar update, and taps the chain at a software-chosen rate. That one tap feeds both a square-wave output pin and a single-cycle periodic event that the interrupt flag logic latches. Each of the two consumers has its own enable.

A 3-bit oscillator-control field decides whether the chain is stopped, held cleared with the oscillator running, or counting. The control state machine has three states: STOPPED (oscillator off, chain cleared), HELD (oscillator on, chain cleared) and COUNTING (chain advances on each time-base enable). The next state follows the written code directly, so every transition is possible: STOPPED to HELD, STOPPED to COUNTING, HELD to STOPPED, HELD to COUNTING, COUNTING to STOPPED and COUNTING to HELD. Each one takes effect one clock after the control field is stored. Because the chain always restarts from zero and the second tick is taken from the rising edge of the top stage, the first tick after counting starts comes half a second late rather than a full second. A flag marks that first shortened second.

There are two reset inputs. The power-on reset initialises everything. The device reset only clears the square-wave enable, and leaves the oscillator and rate fields and the chain untouched.

Top module: `rtc_rate_divider`

## Requirements
- R1: Oscillator code 3'b010 puts the block in COUNTING: `osc_on` is high and the chain advances by one on each clock with `tb_en` high.
- R2: Oscillator codes 3'b110 and 3'b111 put the block in HELD: `osc_on` is high, the chain stays at zero, and neither `prd_pulse` nor `sec_tick` fires.
- R3: All other oscillator codes (000, 001, 011, 100, 101) put the block in STOPPED: `osc_on` is low and no event fires.
- R4: Counting one time-base pulse per step from zero, `sec_tick` is a one-cycle pulse after the 16384th pulse and then after every further 32768 pulses.
- R5: `first_sec` is high from entry into COUNTING until the cycle after the first `sec_tick`, and low after that.
- R6: Rate codes 3 to 15 select a tap of period 2^(code-1) pulses (code 3 is 4 pulses, i.e. 8192 Hz; code 15 is 16384 pulses, i.e. 2 Hz). The first `prd_pulse` comes after half a period, then one per period.
- R7: Rate code 1 selects a period of 128 pulses (256 Hz) and rate code 2 a period of 256 pulses (128 Hz).
- R8: Rate code 0 disables the tap: no `prd_pulse` and `sqw` stays low.
- R9: `prd_pulse` lasts one cycle, fires only while COUNTING with a non-zero rate code, and does not depend on the square-wave enable.
- R10: While COUNTING with its enable set, `sqw` is low in the first half of each tap period and high in the second half. With its enable clear, or outside COUNTING, `sqw` is low.
- R11: `rst_n` low clears the square-wave enable, so `sqw` is low from the next cycle. The oscillator code, the rate code and the chain position are kept, so periodic events continue in phase.
- R12: After power-on reset the oscillator code is 000, the rate code is 0 and the square-wave enable is 0, so all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Device reset, active low, clears only the square-wave enable |
| tb_en | input | 1 | 32.768 kHz time-base enable, one clock per time-base period |
| ctl_we | input | 1 | Write strobe for the oscillator and rate fields |
| ctl_osc | input | 3 | Oscillator-control code to store |
| ctl_rate | input | 4 | Rate-select code to store |
| sqwe_we | input | 1 | Write strobe for the square-wave enable |
| sqwe_d | input | 1 | Square-wave enable value to store |
| sqw | output | 1 | Square-wave output, low when disabled |
| prd_pulse | output | 1 | One-cycle periodic event at the rising edge of the selected tap |
| sec_tick | output | 1 | One-cycle once-per-second update tick |
| first_sec | output | 1 | High during the first, half-length second after counting starts |
| osc_on | output | 1 | Oscillator run request (HELD or COUNTING) |

## Verification
The embedded properties assume the rate code is changed only while the chain is HELD or STOPPED, and that the oscillator code is not toggled back into COUNTING in the same cycle as a second tick. The bench keeps to this: it always parks the chain in HELD, stores the new rate and then releases the chain. It also takes the square-wave enable and the device reset only between bursts of time-base pulses. The time base is driven as back-to-back enables, so tap periods and tick positions are counted exactly in pulses from each release.

// File: rtl/rtc_div_pkg.sv
package rtc_div_pkg;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_HELD     = 2'd1,
        ST_COUNTING = 2'd2
    } osc_state_e;

    localparam logic [2:0] OSC_CODE_RUN = 3'b010;

    // Map the oscillator-control code to the chain state it requests.
    function automatic osc_state_e osc_decode(input logic [2:0] code);
        if (code == OSC_CODE_RUN)
            return ST_COUNTING;
        else if (code[2:1] == 2'b11)
            return ST_HELD;
        else
            return ST_STOPPED;
    endfunction

    // Divider stage whose level forms the selected tap.
    // Stage k toggles with a period of 2^(k+1) time-base pulses.
    function automatic int unsigned rate_to_stage(input logic [3:0] code);
        unique case (code)
            4'd0:    return 0;
            4'd1:    return 6;
            4'd2:    return 7;
            default: return int'(code) - 2;
        endcase
    endfunction

endpackage

// File: rtl/rtc_osc_fsm.sv
module rtc_osc_fsm
    import rtc_div_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic [2:0] osc_code_i,
    input  logic       sec_tick_i,
    output logic       run_o,
    output logic       osc_on_o,
    output logic       first_sec_o
);

    osc_state_e state_q;
    osc_state_e state_d;
    logic       first_q;

    always_comb begin
        state_d = osc_decode(osc_code_i);
    end

    // State register.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= ST_STOPPED;
        else
            state_q <= state_d;
    end

    // First-second flag: set on entry to COUNTING, cleared by the first tick.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            first_q <= 1'b0;
        else if (state_d != ST_COUNTING)
            first_q <= 1'b0;
        else if (sec_tick_i)
            first_q <= 1'b0;
        else if (state_q != ST_COUNTING)
            first_q <= 1'b1;
    end

    // Outputs decoded from the state.
    always_comb begin
        run_o    = 1'b0;
        osc_on_o = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                run_o    = 1'b0;
                osc_on_o = 1'b0;
            end
            ST_HELD: begin
                run_o    = 1'b0;
                osc_on_o = 1'b1;
            end
            ST_COUNTING: begin
                run_o    = 1'b1;
                osc_on_o = 1'b1;
            end
            default: begin
                run_o    = 1'b0;
                osc_on_o = 1'b0;
            end
        endcase
        first_sec_o = first_q;
    end

    // R1
    run_code_chk: assert property (@(posedge clk) disable iff (!por_n)
        run_o |-> $past(osc_code_i) == OSC_CODE_RUN);

    // R5
    first_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        sec_tick_i |=> !first_sec_o);

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              run_i,
    input  logic              tb_en_i,
    output logic [STAGES-1:0] cnt_o,
    output logic              sec_tick_o
);

    // Count value just before the top stage rises.
    localparam logic [STAGES-1:0] TOP_RISE_AT = {1'b0, {(STAGES-1){1'b1}}};

    logic [STAGES-1:0] cnt_q;
    logic              tick_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= run_i && tb_en_i && (cnt_q == TOP_RISE_AT);
            if (!run_i)
                cnt_q <= '0;
            else if (tb_en_i)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o      = cnt_q;
    assign sec_tick_o = tick_q;

    // R4
    sec_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        sec_tick_o |=> !sec_tick_o);

    // R2
    held_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!run_i && !$past(run_i)) |-> cnt_o == '0);

endmodule

// File: rtl/rtc_tap_sel.sv
module rtc_tap_sel
    import rtc_div_pkg::*;
#(
    parameter int STAGES = 15,
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              run_i,
    input  logic              tb_en_i,
    input  logic [STAGES-1:0] cnt_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              sqwe_i,
    output logic              sqw_o,
    output logic              prd_o
);

    localparam int IDX_W = $clog2(STAGES);

    logic [STAGES-1:0] rise_vec;
    logic [IDX_W-1:0]  tap_idx;
    logic              rate_on;
    logic              prd_q;

    // Per-stage rising-edge detect: stage low and every lower stage high.
    for (genvar k = 0; k < STAGES; k++) begin : g_rise
        if (k == 0) begin : g_lsb
            assign rise_vec[k] = ~cnt_i[0];
        end else begin : g_upper
            assign rise_vec[k] = ~cnt_i[k] & (&cnt_i[k-1:0]);
        end
    end

    always_comb begin
        tap_idx = IDX_W'(rate_to_stage(4'(rate_i)));
        rate_on = (rate_i != '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            prd_q <= 1'b0;
        else
            prd_q <= run_i && tb_en_i && rate_on && rise_vec[tap_idx];
    end

    assign prd_o = prd_q;
    assign sqw_o = sqwe_i && run_i && rate_on && cnt_i[tap_idx];

    // R9
    prd_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        prd_o |=> !prd_o);

    // R9
    prd_running_chk: assert property (@(posedge clk) disable iff (!por_n)
        prd_o |-> ($past(run_i) && $past(rate_i) != '0));

endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider
    import rtc_div_pkg::*;
#(
    parameter int STAGES = 15,
    parameter int RATE_W = 4,
    parameter int OSC_W  = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       tb_en,
    input  logic       ctl_we,
    input  logic [2:0] ctl_osc,
    input  logic [3:0] ctl_rate,
    input  logic       sqwe_we,
    input  logic       sqwe_d,
    output logic       sqw,
    output logic       prd_pulse,
    output logic       sec_tick,
    output logic       first_sec,
    output logic       osc_on
);

    logic [OSC_W-1:0]  osc_q;
    logic [RATE_W-1:0] rate_q;
    logic              sqwe_q;
    logic              run;
    logic [STAGES-1:0] cnt;

    // Oscillator and rate fields: only power-on reset touches them.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            osc_q  <= '0;
            rate_q <= '0;
        end else if (ctl_we) begin
            osc_q  <= OSC_W'(ctl_osc);
            rate_q <= RATE_W'(ctl_rate);
        end
    end

    // Square-wave enable: cleared by either reset.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            sqwe_q <= 1'b0;
        else if (!rst_n)
            sqwe_q <= 1'b0;
        else if (sqwe_we)
            sqwe_q <= sqwe_d;
    end

    rtc_osc_fsm i_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .osc_code_i  (3'(osc_q)),
        .sec_tick_i  (sec_tick),
        .run_o       (run),
        .osc_on_o    (osc_on),
        .first_sec_o (first_sec)
    );

    rtc_div_chain #(.STAGES(STAGES)) i_chain (
        .clk        (clk),
        .por_n      (por_n),
        .run_i      (run),
        .tb_en_i    (tb_en),
        .cnt_o      (cnt),
        .sec_tick_o (sec_tick)
    );

    rtc_tap_sel #(.STAGES(STAGES), .RATE_W(RATE_W)) i_tap (
        .clk     (clk),
        .por_n   (por_n),
        .run_i   (run),
        .tb_en_i (tb_en),
        .cnt_i   (cnt),
        .rate_i  (rate_q),
        .sqwe_i  (sqwe_q),
        .sqw_o   (sqw),
        .prd_o   (prd_pulse)
    );

    // R11
    rst_sqw_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> !sqw);

    // R3
    idle_no_evt_chk: assert property (@(posedge clk) disable iff (!por_n)
        !osc_on |=> (!prd_pulse && !sec_tick));

    // R8
    zero_rate_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rate_q == '0) |-> (!sqw && !prd_pulse));

endmodule

// File: tb/test_rtc_rate_divider.sv
`timescale 1ns/100ps
module test_rtc_rate_divider;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b0;
    logic       tb_en = 1'b0;
    logic       ctl_we = 1'b0;
    logic [2:0] ctl_osc = 3'b000;
    logic [3:0] ctl_rate = 4'd0;
    logic       sqwe_we = 1'b0;
    logic       sqwe_d = 1'b0;
    logic       sqw, prd_pulse, sec_tick, first_sec, osc_on;

    always #2.5 clk = ~clk;

    rtc_rate_divider i_rtc_rate_divider (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tb_en(tb_en),
        .ctl_we(ctl_we), .ctl_osc(ctl_osc), .ctl_rate(ctl_rate),
        .sqwe_we(sqwe_we), .sqwe_d(sqwe_d),
        .sqw(sqw), .prd_pulse(prd_pulse), .sec_tick(sec_tick),
        .first_sec(first_sec), .osc_on(osc_on)
    );

    int checks = 0;
    int errors = 0;
    int pc = 0;
    logic pc_clr = 1'b0;
    int prd_q[$];
    int sec_q[$];
    bit chk_sqw = 0;
    bit cur_run = 0;
    bit cur_sqwe = 0;
    int cur_r = 0;
    int cur_k = 0;
    int sqw_bad = 0;
    string cur_req = "R6";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pulse counter of the bench's own time base.
    always @(posedge clk) begin
        if (pc_clr) pc <= 0;
        else if (tb_en) pc <= pc + 1;
    end

    // Monitor: pops expected event positions and compares them.
    always @(negedge clk) begin
        if (prd_pulse) begin
            if (prd_q.size() == 0)
                check(0, cur_req, "unexpected prd_pulse at pulse", pc, -1);
            else begin
                int e;
                e = prd_q.pop_front();
                check(pc == e, cur_req, "prd_pulse position", pc, e);
            end
        end
        if (sec_tick) begin
            if (sec_q.size() == 0)
                check(0, "R4", "unexpected sec_tick at pulse", pc, -1);
            else begin
                int e;
                e = sec_q.pop_front();
                check(pc == e, "R4", "sec_tick position", pc, e);
            end
        end
        if (chk_sqw) begin
            bit exp_sqw;
            exp_sqw = cur_run && cur_sqwe && (cur_r != 0) && (((pc % 32768) >> cur_k) & 1);
            if (sqw !== exp_sqw) sqw_bad++;
        end
    end

    function automatic int stage_of(input int r);
        if (r == 1) return 6;
        if (r == 2) return 7;
        return r - 2;
    endfunction

    // Driver side of the scoreboard: expected periodic events in (lo, hi].
    task automatic push_prd(input int r, input int lo, input int hi);
        int k;
        if (r == 0) return;
        k = stage_of(r);
        for (int t = (1 << k); t <= hi; t += (1 << (k + 1)))
            if (t > lo) prd_q.push_back(t);
    endtask

    task automatic push_sec(input int hi);
        for (int t = 16384; t <= hi; t += 32768) sec_q.push_back(t);
    endtask

    task automatic write_ctl(input logic [2:0] o, input logic [3:0] r);
        @(negedge clk);
        ctl_we = 1'b1; ctl_osc = o; ctl_rate = r;
        @(negedge clk);
        ctl_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_sqwe(input logic v);
        @(negedge clk);
        sqwe_we = 1'b1; sqwe_d = v;
        @(negedge clk);
        sqwe_we = 1'b0;
        cur_sqwe = v;
    endtask

    task automatic pulse(input int n);
        chk_sqw = 1;
        repeat (n) begin
            @(negedge clk);
            tb_en = 1'b1;
        end
        @(negedge clk);
        tb_en = 1'b0;
        @(negedge clk);
        chk_sqw = 0;
    endtask

    // Park in HELD, store rate, release into COUNTING, restart pulse count.
    task automatic start_rate(input int r);
        chk_sqw = 0;
        write_ctl(3'b110, 4'(r));
        write_ctl(3'b010, 4'(r));
        pc_clr = 1'b1;
        @(negedge clk);
        pc_clr = 1'b0;
        cur_r = r; cur_k = (r == 0) ? 0 : stage_of(r); cur_run = 1;
        sqw_bad = 0;
    endtask

    task automatic end_test(input string req);
        check(prd_q.size() == 0, req, "missing prd_pulse events", prd_q.size(), 0);
        check(sec_q.size() == 0, "R4", "missing sec_tick events", sec_q.size(), 0);
        check(sqw_bad == 0, "R10", "sqw mismatching cycles", sqw_bad, 0);
        prd_q.delete(); sec_q.delete();
    endtask

    task automatic rate_test(input int r, input int n, input string req);
        cur_req = req;
        start_rate(r);
        check(osc_on == 1'b1, "R1", "osc_on while counting", osc_on, 1);
        push_prd(r, 0, n);
        pulse(n);
        end_test(req);
    endtask

    task automatic idle_test(input logic [2:0] o, input bit exp_on, input string req);
        cur_req = req;
        chk_sqw = 0;
        write_ctl(o, 4'd3);
        cur_r = 3; cur_k = 1; cur_run = 0; sqw_bad = 0;
        check(osc_on == exp_on, req, "osc_on for code", osc_on, exp_on);
        pulse(100);
        end_test(req);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog: cycles=%0d expected=end of run", 200000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check({sqw, prd_pulse, sec_tick, first_sec, osc_on} == 5'b0, "R12",
              "outputs after power-on", {sqw, prd_pulse, sec_tick, first_sec, osc_on}, 0);

        write_sqwe(1'b1);
        rate_test(3, 200, "R6");   // 8192 Hz, period 4
        rate_test(1, 600, "R7");   // 256 Hz, period 128
        rate_test(2, 600, "R7");   // 128 Hz, period 256
        rate_test(9, 600, "R6");   // 128 Hz, period 256
        rate_test(0, 300, "R8");   // tap disabled
        check(sqw == 1'b0, "R8", "sqw with rate 0", sqw, 0);

        // R2 held codes, R3 stopped codes
        idle_test(3'b110, 1'b1, "R2");
        idle_test(3'b111, 1'b1, "R2");
        idle_test(3'b000, 1'b0, "R3");
        idle_test(3'b101, 1'b0, "R3");
        idle_test(3'b011, 1'b0, "R3");

        // R4/R5/R9: slowest rate, square wave disabled, second ticks
        write_sqwe(1'b0);
        cur_req = "R9";
        start_rate(15);
        check(first_sec == 1'b1, "R5", "first_sec after release", first_sec, 1);
        push_prd(15, 0, 50000);
        push_sec(50000);
        pulse(16000);
        check(first_sec == 1'b1, "R5", "first_sec before first tick", first_sec, 1);
        pulse(34000);
        check(first_sec == 1'b0, "R5", "first_sec after first tick", first_sec, 0);
        end_test("R9");

        // R11: device reset clears enable only
        write_sqwe(1'b1);
        cur_req = "R11";
        start_rate(3);
        push_prd(3, 0, 128);
        pulse(64);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_sqwe = 0;
        @(negedge clk);
        check(sqw == 1'b0, "R11", "sqw after device reset", sqw, 0);
        check(osc_on == 1'b1, "R11", "osc_on kept over device reset", osc_on, 1);
        pulse(64);
        end_test("R11");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule